// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns the operand fields of a memory instruction into the 32-bit effective address that the memory pipeline uses. It supports three address forms: the base register alone, the base register plus a sign-extended 16-bit immediate, and the base register plus an index register. A base register number of zero always stands for the constant zero and never for the contents of register zero.

Along with the address, the block produces big-endian byte-lane enables and store data replicated into the lanes for the access size. For update forms it produces a write to the register file that puts the computed address back into the base register. It flags illegal encodings and illegal update combinations. A small return path takes the 32-bit word read from memory and extracts the addressed byte, half-word or word, zero-extended. It uses the address and size held from the previous request.

All request outputs are registered, so they appear one clock after the request is accepted. The load-extraction output is combinational from the held address and size and the read bus.

Top module: `agu_ls`

## Requirements
- R1: After reset, `out_valid`, `wb_en` and `bad` are 0. Every request accepted with `req_valid`=1 produces its results on the outputs exactly one clock later, with `out_valid`=1.
- R2: In every mode, a `base_idx` of 0 makes the base operand 0 whatever value is on `base_val`.
- R3: `mode` 0 gives EA = base. `mode` 1 gives EA = base + sign-extended `imm`. `mode` 2 gives EA = base + `idx_val`. All additions are modulo 2^32.
- R4: `mode` 3 and `size` 3 are illegal encodings and set `bad`. `size` codes are 0 = byte, 1 = half-word and 2 = word.
- R5: A legal request with `upd`=1 raises `wb_en`, with `wb_idx` = `base_idx` and `wb_data` = EA. Load and base writeback are reported in the same cycle.
- R6: An update request is illegal, setting `bad` and keeping `wb_en` at 0, when `mode` is 0, when `base_idx` is 0, or when it is a load (`is_store`=0) whose `dst_idx` equals `base_idx`. A store with `dst_idx` equal to `base_idx` is legal.
- R7: Byte enables are big-endian: `be[3]` is the lane at address offset 0 (bus bits 31:24) and `be[0]` is offset 3. A byte access enables only `be[3-EA[1:0]]`. A half-word enables 4'b1100 when EA[1]=0 and 4'b0011 when EA[1]=1. A word enables 4'b1111. An illegal request gives 4'b0000.
- R8: `wdata` holds the low byte of `st_data` copied into all four lanes for a byte access, and the low 16 bits copied into both halves for a half-word. It holds `st_data` unchanged for a word.
- R9: `ld_val` is the lane of `rd_bus` addressed by the held EA and size, zero-extended: byte lane `rd_bus[31-8*EA[1:0] -: 8]`, half `rd_bus[31:16]` when EA[1]=0 and `rd_bus[15:0]` otherwise, or the whole word.
- R10: A cycle with `req_valid`=0 gives `out_valid`=0 and `wb_en`=0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| mode | input | 2 | Address form (0 base, 1 base+imm, 2 base+index, 3 illegal) |
| size | input | 2 | Access size (0 byte, 1 half, 2 word, 3 illegal) |
| is_store | input | 1 | 1 for store, 0 for load |
| upd | input | 1 | Update form: write EA back to base |
| base_idx | input | RIDX | Base register number |
| base_val | input | 32 | Base register contents |
| idx_val | input | 32 | Index register contents |
| imm | input | IMMW | Signed displacement |
| dst_idx | input | RIDX | Load destination / store source register number |
| st_data | input | 32 | Store source register contents |
| rd_bus | input | 32 | Word read from memory for the held request |
| out_valid | output | 1 | Registered results valid |
| ea | output | 32 | Effective address |
| be | output | 4 | Big-endian byte enables |
| wdata | output | 32 | Lane-replicated store data |
| wb_en | output | 1 | Base-register writeback enable |
| wb_idx | output | RIDX | Writeback register number |
| wb_data | output | 32 | Writeback value (EA) |
| bad | output | 1 | Illegal form |
| ld_val | output | 32 | Extracted, zero-extended load value |

## Verification
The assertions assume that the register values on `base_val`, `idx_val` and `st_data` are stable and known whenever `req_valid` is high. They also assume that `rd_bus` belongs to the request currently held on the outputs. The stimulus keeps to this by changing every input only on the falling clock edge. It sets `rd_bus` only after the registered results of a request have appeared. It sweeps every combination of mode, size, update, load or store and low address bits, with base register numbers of zero, equal to the destination and distinct from it. It includes a negative displacement, so the sign extension and zero-base rules are exercised together.

// File: rtl/agu_ls.sv
module agu_ls #(
  parameter int RIDX = 5,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      mode,
  input  logic [1:0]      size,
  input  logic            is_store,
  input  logic            upd,
  input  logic [RIDX-1:0] base_idx,
  input  logic [31:0]     base_val,
  input  logic [31:0]     idx_val,
  input  logic [IMMW-1:0] imm,
  input  logic [RIDX-1:0] dst_idx,
  input  logic [31:0]     st_data,
  input  logic [31:0]     rd_bus,
  output logic            out_valid,
  output logic [31:0]     ea,
  output logic [3:0]      be,
  output logic [31:0]     wdata,
  output logic            wb_en,
  output logic [RIDX-1:0] wb_idx,
  output logic [31:0]     wb_data,
  output logic            bad,
  output logic [31:0]     ld_val
);

  localparam int EXTW = 32 - IMMW;

  logic [31:0] base_eff, imm_ext, ea_n, wd_n;
  logic [3:0]  be_n;
  logic        bad_n, base_zero;
  logic [1:0]  size_q;

  assign base_zero = (base_idx == '0);
  assign base_eff  = base_zero ? 32'd0 : base_val;
  assign imm_ext   = {{EXTW{imm[IMMW-1]}}, imm};

  always_comb begin
    case (mode)
      2'd1:    ea_n = base_eff + imm_ext;
      2'd2:    ea_n = base_eff + idx_val;
      default: ea_n = base_eff;
    endcase
  end

  assign bad_n = (mode == 2'd3) || (size == 2'd3) ||
                 (upd && ((mode == 2'd0) || base_zero ||
                          (!is_store && (dst_idx == base_idx))));

  always_comb begin
    be_n = 4'b0000;
    wd_n = st_data;
    case (size)
      2'd0: begin
        be_n = 4'b1000 >> ea_n[1:0];
        wd_n = {4{st_data[7:0]}};
      end
      2'd1: begin
        be_n = ea_n[1] ? 4'b0011 : 4'b1100;
        wd_n = {2{st_data[15:0]}};
      end
      2'd2: be_n = 4'b1111;
      default: be_n = 4'b0000;
    endcase
    if (bad_n) be_n = 4'b0000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      bad       <= 1'b0;
      ea        <= '0;
      be        <= '0;
      wdata     <= '0;
      wb_idx    <= '0;
      wb_data   <= '0;
      size_q    <= '0;
    end else begin
      out_valid <= req_valid;
      wb_en     <= req_valid && upd && !bad_n;
      bad       <= req_valid && bad_n;
      if (req_valid) begin
        ea      <= ea_n;
        be      <= be_n;
        wdata   <= wd_n;
        wb_idx  <= base_idx;
        wb_data <= ea_n;
        size_q  <= size;
      end
    end
  end

  always_comb begin
    case (size_q)
      2'd0:    ld_val = {24'd0, rd_bus[8*(3 - int'(ea[1:0])) +: 8]};
      2'd1:    ld_val = {16'd0, (ea[1] ? rd_bus[15:0] : rd_bus[31:16])};
      default: ld_val = rd_bus;
    endcase
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !wb_en && !bad);

  assert_zero_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && base_idx == '0 && mode == 2'd0 |=> ea == 32'd0);

  assert_bad_no_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> be == 4'b0000 && !wb_en);

  assert_lane_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !bad |-> $countones(be) == 1 || $countones(be) == 2 || $countones(be) == 4);

  assert_wb_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_idx != '0 && out_valid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && !wb_en);

  assert_illegal_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 2'd3 |=> bad);

endmodule

// File: tb/tb_agu_ls.sv
module tb_agu_ls;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  mode = '0, size = '0;
  logic        is_store = 1'b0, upd = 1'b0;
  logic [4:0]  base_idx = '0, dst_idx = '0;
  logic [31:0] base_val = '0, idx_val = '0, st_data = '0, rd_bus = '0;
  logic [15:0] imm = '0;
  logic        out_valid, wb_en, bad;
  logic [31:0] ea, wdata, wb_data, ld_val;
  logic [3:0]  be;
  logic [4:0]  wb_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  agu_ls dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .size(size),
    .is_store(is_store), .upd(upd), .base_idx(base_idx), .base_val(base_val),
    .idx_val(idx_val), .imm(imm), .dst_idx(dst_idx), .st_data(st_data),
    .rd_bus(rd_bus), .out_valid(out_valid), .ea(ea), .be(be), .wdata(wdata),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .bad(bad), .ld_val(ld_val)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] e_ea, e_base, e_wd, e_ld;
    logic [3:0]  e_be;
    logic        e_bad;
    int          bidx [3];
    bidx[0] = 0; bidx[1] = 3; bidx[2] = 9;
    repeat (3) @(negedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", {31'd0, out_valid}, 0);
    chk(wb_en == 0, "R1 reset wb_en", {31'd0, wb_en}, 0);
    chk(bad == 0, "R1 reset bad", {31'd0, bad}, 0);
    rst_n = 1'b1;
    for (int bi = 0; bi < 3; bi++)
    for (int dsel = 0; dsel < 2; dsel++)
    for (int m = 0; m < 4; m++)
    for (int s = 0; s < 4; s++)
    for (int u = 0; u < 2; u++)
    for (int st = 0; st < 2; st++)
    for (int lo = 0; lo < 4; lo++) begin
      @(negedge clk);
      req_valid = 1'b1;
      mode = 2'(m); size = 2'(s); upd = u[0]; is_store = st[0];
      base_idx = 5'(bidx[bi]);
      dst_idx = (dsel == 0) ? 5'd3 : 5'd17;
      base_val = 32'h1234_5670 + 32'(lo);
      idx_val  = 32'h0000_0101 + 32'(lo * 5);
      imm      = (lo[0]) ? 16'hFFF7 : 16'h0102;
      st_data  = 32'hA5B6_C7D8 ^ 32'(lo * 32'h0101_0101);
      e_base = (bidx[bi] == 0) ? 32'd0 : base_val;
      case (m)
        1: e_ea = e_base + {{16{imm[15]}}, imm};
        2: e_ea = e_base + idx_val;
        default: e_ea = e_base;
      endcase
      e_bad = (m == 3) || (s == 3) ||
              (u == 1 && (m == 0 || bidx[bi] == 0 || (st == 0 && dst_idx == base_idx)));
      case (s)
        0: begin e_be = 4'b1000 >> e_ea[1:0]; e_wd = {4{st_data[7:0]}}; end
        1: begin e_be = e_ea[1] ? 4'b0011 : 4'b1100; e_wd = {2{st_data[15:0]}}; end
        2: begin e_be = 4'b1111; e_wd = st_data; end
        default: begin e_be = 4'b0000; e_wd = st_data; end
      endcase
      if (e_bad) e_be = 4'b0000;
      @(negedge clk);
      chk(out_valid == 1, "R1 out_valid", {31'd0, out_valid}, 1);
      chk(ea == e_ea, (bidx[bi] == 0) ? "R2 zero base ea" : "R3 ea", ea, e_ea);
      chk(bad == e_bad, (m == 3 || s == 3) ? "R4 bad" : "R6 bad", {31'd0, bad}, {31'd0, e_bad});
      chk(be == e_be, "R7 be", {28'd0, be}, {28'd0, e_be});
      if (!e_bad && s != 3) chk(wdata == e_wd, "R8 wdata", wdata, e_wd);
      chk(wb_en == (u == 1 && !e_bad), (u == 1) ? "R6 wb_en" : "R5 wb_en",
          {31'd0, wb_en}, {31'd0, (u == 1 && !e_bad)});
      if (wb_en) begin
        chk(wb_idx == base_idx, "R5 wb_idx", {27'd0, wb_idx}, {27'd0, base_idx});
        chk(wb_data == e_ea, "R5 wb_data", wb_data, e_ea);
      end
      if (s != 3) begin
        rd_bus = 32'hA1B2_C3D4 + 32'(lo);
        case (s)
          0: e_ld = {24'd0, 8'(rd_bus >> (8 * (3 - int'(e_ea[1:0]))))};
          1: e_ld = {16'd0, (e_ea[1] ? rd_bus[15:0] : rd_bus[31:16])};
          default: e_ld = rd_bus;
        endcase
        #1;
        chk(ld_val == e_ld, "R9 ld_val", ld_val, e_ld);
      end
    end
    @(negedge clk);
    req_valid = 1'b0; upd = 1'b1; mode = 2'd1; base_idx = 5'd4; dst_idx = 5'd8;
    @(negedge clk);
    chk(out_valid == 0, "R10 idle out_valid", {31'd0, out_valid}, 0);
    chk(wb_en == 0, "R10 idle wb_en", {31'd0, wb_en}, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule